// File: doc/BRIEF.md
# Page Write Buffer with Program Timer

This block sits between a two-wire bus slave engine and a byte-wide non-volatile array. When the bus engine decodes a write, it opens a transaction with a full byte address. The upper bits select a 256-byte page and the low eight bits set a byte pointer. The engine then streams data bytes in. Each byte lands in an on-chip page buffer at the pointer, and the pointer steps within the page. When the engine reports the stop condition, the block commits every buffered location to the array in one timed programming cycle. During that cycle it holds `busy` high, and the bus engine uses `busy` to withhold acknowledges.

The data input is a valid/ready stream. `byte_ready` is high only while a transaction is open and no program cycle runs. A byte counts only in a cycle where `byte_valid` and `byte_ready` are both high. Since `byte_ready` is combinational from state and never waits on the array, an accepted byte can be acknowledged at once. The array side is a write-only stream (`pgm_valid`, `pgm_addr`, `pgm_data`) with no back-pressure: the array must take one byte per cycle. `next_addr` gives the address that follows the last loaded byte, so the engine can refresh its current-address pointer. The program duration `PROG_CYCLES` is counted in system clocks and must be at least the page size.

Top module: `page_wbuf`

## Requirements
- R1: After reset, and in standby, `busy`, `byte_ready` and `pgm_valid` are 0. `txn_open` in standby opens a transaction and raises `byte_ready`. `next_addr` then equals `txn_addr`: the page is `txn_addr[16:8]` and the pointer is `txn_addr[7:0]`.
- R2: Each accepted byte is stored at the pointer. Then only the low 8 bits of `next_addr` increment, modulo 256. The upper 9 bits stay fixed.
- R3: The pointer wraps from 0xFF to 0x00 of the same page. A transaction longer than 256 bytes overwrites earlier bytes, and the commit carries the latest value once per location.
- R4: A stop while a transaction is open, with at least one byte loaded and `wp` low, starts programming. `busy` rises at the stop edge and stays high for exactly `PROG_CYCLES` cycles.
- R5: During programming, `pgm_valid` pulses once for each loaded location and never for an unloaded one. The pulses come in ascending in-page index order, with `pgm_addr` = {page, index}.
- R6: While `busy` is high, `byte_ready` is 0 and `txn_open`, `byte_valid` and `stop` have no effect. `next_addr` holds its value, and nothing driven then appears in a later commit.
- R7: A stop with `wp` high commits nothing, never raises `busy`, and discards the buffered bytes.
- R8: A stop with no byte loaded returns to standby without raising `busy`.
- R9: A byte accepted in the same cycle as the stop is part of the commit.
- R10: `txn_open` during an open transaction discards the bytes loaded so far and restarts at the new address.
- R11: When programming ends, the block is in standby: `busy` and `byte_ready` are 0, and `next_addr` holds the final address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_open | input | 1 | Open (or restart) a write transaction |
| txn_addr | input | ADDR_W | Start byte address of the transaction |
| byte_valid | input | 1 | Data byte offered |
| byte_ready | output | 1 | Data byte can be taken (also the acknowledge) |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | Stop condition seen on the bus |
| wp | input | 1 | Write-protect level, sampled at stop |
| busy | output | 1 | Programming cycle in progress |
| next_addr | output | ADDR_W | Address following the last loaded byte |
| pgm_valid | output | 1 | Array write strobe |
| pgm_addr | output | ADDR_W | Array write address |
| pgm_data | output | 8 | Array write data |

## Verification
Two events can fall in the same cycle here. A data byte can be accepted on the very edge that also carries the stop, so loading and the start of programming coincide. The bench provokes this by raising `byte_valid` and `stop` together in one cycle, at the last address of the array. It judges the result in two ways. The scoreboard must receive that byte as a commit at address 0x1FFFF, and `next_addr` must show the pointer wrapped to 0x1FF00. The same test also repeats the open/stop pairing under write protect, where the coinciding byte must vanish instead.

// File: rtl/page_wbuf_pkg.sv
package page_wbuf_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_LOAD = 2'd1,
    PW_PROG = 2'd2
  } pw_state_e;
endpackage

// File: rtl/page_wbuf_store.sv
module page_wbuf_store #(
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  input  logic              rd_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     mem_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (wr_en && !clr_all) mem_q[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (clr_all) begin
      vld_q <= '0;
    end else begin
      if (wr_en)  vld_q[wr_idx] <= 1'b1;
      if (rd_clr) vld_q[rd_idx] <= 1'b0;
    end
  end

  assign rd_data = mem_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];

  // R3: a discard leaves no location marked as loaded
  a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (vld_q == '0));

  // R5: a committed location is not offered twice
  a_r5_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !wr_en && !clr_all) |=> !vld_q[$past(rd_idx)]);
endmodule

// File: rtl/page_wbuf_timer.sv
module page_wbuf_timer #(
  parameter int PROG_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic run,
  output logic done
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start && !run_q) begin
      cnt_q <= CNT_W'(PROG_CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign run  = run_q;
  assign done = run_q && (cnt_q == '0);

  // R4: the timer never stops early
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !done) |=> (run_q && (cnt_q == $past(cnt_q) - 1'b1)));
endmodule

// File: rtl/page_wbuf.sv
module page_wbuf
  import page_wbuf_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int PAGE_W      = 8,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_open,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop,
  input  logic              wp,
  output logic              busy,
  output logic [ADDR_W-1:0] next_addr,
  output logic              pgm_valid,
  output logic [ADDR_W-1:0] pgm_addr,
  output logic [DATA_W-1:0] pgm_data
);
  localparam int PG_W   = ADDR_W - PAGE_W;
  localparam int SCAN_W = PAGE_W + 1;

  pw_state_e         state_q, state_d;
  logic [PG_W-1:0]   page_q, page_d;
  logic [PAGE_W-1:0] ptr_q, ptr_d;
  logic              have_q, have_d;
  logic [SCAN_W-1:0] scan_q, scan_d;
  logic              clr_all, accept, tmr_start, tmr_run, tmr_done;
  logic              rd_vld, scan_live;
  logic [DATA_W-1:0] rd_data;

  assign byte_ready = (state_q == PW_LOAD);
  assign accept     = byte_valid && byte_ready;
  assign busy       = (state_q == PW_PROG);
  assign scan_live  = busy && !scan_q[PAGE_W];

  always_comb begin
    state_d   = state_q;
    page_d    = page_q;
    ptr_d     = ptr_q;
    have_d    = have_q;
    scan_d    = scan_q;
    clr_all   = 1'b0;
    tmr_start = 1'b0;
    unique case (state_q)
      PW_IDLE: begin
        if (txn_open) begin
          state_d = PW_LOAD;
          page_d  = txn_addr[ADDR_W-1:PAGE_W];
          ptr_d   = txn_addr[PAGE_W-1:0];
          have_d  = 1'b0;
          clr_all = 1'b1;
        end
      end
      PW_LOAD: begin
        if (accept) begin
          ptr_d  = ptr_q + 1'b1;
          have_d = 1'b1;
        end
        if (stop) begin
          if (wp || !(have_q || accept)) begin
            state_d = PW_IDLE;
            clr_all = 1'b1;
            have_d  = 1'b0;
          end else begin
            state_d   = PW_PROG;
            tmr_start = 1'b1;
            scan_d    = '0;
          end
        end else if (txn_open) begin
          page_d  = txn_addr[ADDR_W-1:PAGE_W];
          ptr_d   = txn_addr[PAGE_W-1:0];
          have_d  = 1'b0;
          clr_all = 1'b1;
        end
      end
      PW_PROG: begin
        if (scan_live) scan_d = scan_q + 1'b1;
        if (tmr_done) begin
          state_d = PW_IDLE;
          have_d  = 1'b0;
        end
      end
      default: state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      page_q  <= '0;
      ptr_q   <= '0;
      have_q  <= 1'b0;
      scan_q  <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      ptr_q   <= ptr_d;
      have_q  <= have_d;
      scan_q  <= scan_d;
    end
  end

  page_wbuf_store #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (clr_all),
    .wr_en   (accept),
    .wr_idx  (ptr_q),
    .wr_data (byte_data),
    .rd_idx  (scan_q[PAGE_W-1:0]),
    .rd_clr  (pgm_valid),
    .rd_data (rd_data),
    .rd_vld  (rd_vld)
  );

  page_wbuf_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  assign next_addr = {page_q, ptr_q};
  assign pgm_valid = scan_live && rd_vld;
  assign pgm_addr  = {page_q, scan_q[PAGE_W-1:0]};
  assign pgm_data  = rd_data;

  // R4: programming only begins from a stop
  a_r4_enter_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  // R4: busy tracks the program timer
  a_r4_busy_timer: assert property (@(posedge clk) disable iff (!rst_n)
    busy == tmr_run);

  // R5: array writes only inside the program cycle
  a_r5_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_valid |-> busy);

  // R2: a plain accepted byte steps only the low pointer
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !stop && !txn_open) |=>
      (next_addr[PAGE_W-1:0] == PAGE_W'($past(next_addr[PAGE_W-1:0]) + 1'b1)) &&
      (next_addr[ADDR_W-1:PAGE_W] == $past(next_addr[ADDR_W-1:PAGE_W])));

  // R6: the reported address is frozen while programming
  a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(next_addr));

  // R7: a protected stop never starts a program cycle
  a_r7_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_ready && stop && wp) |=> !busy);
endmodule

// File: tb/sim_page_wbuf.sv
module sim_page_wbuf;
  localparam int ADDR_W = 17;
  localparam int PROG   = 300;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              txn_open = 1'b0;
  logic [ADDR_W-1:0] txn_addr = '0;
  logic              byte_valid = 1'b0;
  logic              byte_ready;
  logic [7:0]        byte_data = '0;
  logic              stop = 1'b0;
  logic              wp = 1'b0;
  logic              busy;
  logic [ADDR_W-1:0] next_addr;
  logic              pgm_valid;
  logic [ADDR_W-1:0] pgm_addr;
  logic [7:0]        pgm_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [ADDR_W-1:0] exp_addr_q[$];
  logic [7:0]        exp_data_q[$];
  logic [7:0]        m_dat [256];
  bit                m_vld [256];
  logic [8:0]        m_page;

  always #2 clk = ~clk;

  page_wbuf #(.ADDR_W(ADDR_W), .PAGE_W(8), .DATA_W(8), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .txn_open(txn_open), .txn_addr(txn_addr),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .stop(stop), .wp(wp), .busy(busy), .next_addr(next_addr),
    .pgm_valid(pgm_valid), .pgm_addr(pgm_addr), .pgm_data(pgm_data));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected commits as the design produces them
  always @(negedge clk) begin
    if (rst_n && pgm_valid) begin
      if (exp_addr_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected commit addr", 32'(pgm_addr), 32'h0);
      end else begin
        logic [ADDR_W-1:0] ea;
        logic [7:0]        ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        chk(pgm_addr == ea, "R5", "commit addr", 32'(pgm_addr), 32'(ea));
        chk(pgm_data == ed, "R3", "commit data", 32'(pgm_data), 32'(ed));
      end
    end
  end

  task automatic model_clear();
    for (int i = 0; i < 256; i++) m_vld[i] = 1'b0;
  endtask

  task automatic open_txn(input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    txn_open = 1'b1; txn_addr = a;
    @(posedge clk); #1;
    txn_open = 1'b0;
    model_clear();
    m_page = a[16:8];
  endtask

  task automatic send_byte(input logic [7:0] d);
    logic [7:0] idx;
    idx = next_addr[7:0];
    byte_valid = 1'b1; byte_data = d;
    @(posedge clk); #1;
    byte_valid = 1'b0;
    m_dat[idx] = d; m_vld[idx] = 1'b1;
  endtask

  // stop, optionally with a byte in the same cycle; then judge the program phase
  task automatic do_stop(input bit prot, input bit with_byte, input logic [7:0] d,
                         input bit expect_prog, input string req);
    logic [ADDR_W-1:0] held;
    int n;
    if (with_byte) begin
      m_dat[next_addr[7:0]] = d; m_vld[next_addr[7:0]] = 1'b1;
    end
    byte_valid = with_byte; byte_data = d; stop = 1'b1; wp = prot;
    if (expect_prog)
      for (int i = 0; i < 256; i++)
        if (m_vld[i]) begin
          exp_addr_q.push_back({m_page, 8'(i)});
          exp_data_q.push_back(m_dat[i]);
        end
    @(posedge clk); #1;
    byte_valid = 1'b0; stop = 1'b0; wp = 1'b0;
    model_clear();
    if (!expect_prog) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        chk(busy == 1'b0, req, "busy after stop", 32'(busy), 32'h0);
      end
      return;
    end
    n = 0;
    held = next_addr;
    for (int c = 0; c < PROG + 20; c++) begin
      @(negedge clk);
      if (!busy) break;
      n++;
      if (c == 10) begin
        chk(byte_ready == 1'b0, "R6", "ready while busy", 32'(byte_ready), 32'h0);
        txn_open = 1'b1; txn_addr = 17'h0AA55; byte_valid = 1'b1;
        byte_data = 8'hEE; stop = 1'b1;
      end
      if (c == 20) begin
        txn_open = 1'b0; byte_valid = 1'b0; stop = 1'b0;
      end
    end
    chk(n == PROG, "R4", "busy length", 32'(n), 32'(PROG));
    chk(next_addr == held, "R6", "addr held", 32'(next_addr), 32'(held));
    chk(byte_ready == 1'b0, "R11", "ready in standby", 32'(byte_ready), 32'h0);
    chk(exp_addr_q.size() == 0, "R5", "commits outstanding",
        32'(exp_addr_q.size()), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    m_page = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R1", "reset busy", 32'(busy), 0);
    chk(byte_ready == 0, "R1", "reset ready", 32'(byte_ready), 0);
    chk(pgm_valid == 0, "R1", "reset pgm_valid", 32'(pgm_valid), 0);

    // single byte write
    open_txn(17'h10042);
    chk(byte_ready == 1, "R1", "ready when open", 32'(byte_ready), 1);
    chk(next_addr == 17'h10042, "R1", "open addr", 32'(next_addr), 32'h10042);
    send_byte(8'hA5);
    chk(next_addr == 17'h10043, "R2", "step addr", 32'(next_addr), 32'h10043);
    do_stop(1'b0, 1'b0, 8'h00, 1'b1, "R4");
    chk(next_addr == 17'h10043, "R11", "final addr", 32'(next_addr), 32'h10043);

    // sparse run across 0xFF boundary (wrap inside page)
    open_txn(17'h080FD);
    for (int i = 0; i < 5; i++) send_byte(8'(8'h30 + i));
    chk(next_addr == 17'h08002, "R3", "wrap addr", 32'(next_addr), 32'h08002);
    do_stop(1'b0, 1'b0, 8'h00, 1'b1, "R5");

    // write protected: nothing committed, buffer discarded
    open_txn(17'h0C010);
    for (int i = 0; i < 3; i++) send_byte(8'(8'h70 + i));
    do_stop(1'b1, 1'b0, 8'h00, 1'b0, "R7");
    open_txn(17'h0C020);
    send_byte(8'h99);
    do_stop(1'b0, 1'b0, 8'h00, 1'b1, "R7");

    // no data: dummy write
    open_txn(17'h00100);
    do_stop(1'b0, 1'b0, 8'h00, 1'b0, "R8");
    chk(byte_ready == 0, "R8", "standby after empty stop", 32'(byte_ready), 0);

    // restart mid transaction
    open_txn(17'h03310);
    send_byte(8'h11); send_byte(8'h22);
    open_txn(17'h04480);
    chk(next_addr == 17'h04480, "R10", "reopen addr", 32'(next_addr), 32'h04480);
    send_byte(8'h33);
    do_stop(1'b0, 1'b0, 8'h00, 1'b1, "R10");

    // overflow: 258 bytes overwrite the first two
    open_txn(17'h123FE);
    for (int i = 0; i < 258; i++) send_byte(8'(i ^ 8'h5A));
    chk(next_addr == 17'h12300, "R3", "overflow addr", 32'(next_addr), 32'h12300);
    do_stop(1'b0, 1'b0, 8'h00, 1'b1, "R3");

    // byte and stop in the same cycle at the top of the array
    open_txn(17'h1FFFF);
    do_stop(1'b0, 1'b1, 8'hC3, 1'b1, "R9");
    chk(next_addr == 17'h1FF00, "R9", "same-cycle addr", 32'(next_addr), 32'h1FF00);

    // same pairing under protect: byte vanishes
    open_txn(17'h1FF10);
    do_stop(1'b1, 1'b1, 8'h3C, 1'b0, "R7");
    open_txn(17'h1FF20);
    send_byte(8'h01);
    do_stop(1'b0, 1'b0, 8'h00, 1'b1, "R7");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule